// File: doc/BRIEF.md
# Serial Pattern Match Gauge

This block watches a stream of bits that an operator enters by hand and shows how far the stream has progressed toward the target pattern 1, 0, 1, 1. There are two push-buttons. One enters a 0 and the other enters a 1. Each button passes through a two-flop synchroniser, a counter-based debouncer and a press-edge detector, so each physical press delivers exactly one bit.

A Moore state machine holds the length of the longest prefix of the pattern that the received bits currently end with. Matches overlap, so after a full match the machine keeps every tail that is still a useful prefix. Four active-low LEDs show that length as a thermometer gauge. For testing, the length and a full-match flag are also brought out as plain outputs.

Top module: `seqgauge_top`

## Requirements
- R1: While `rst_n` is low and after it is released, `match_level` is 0, `full_match` is 0 and `led_n` is 4'b1111. The reset state holds until the first accepted bit.
- R2: The pattern is 1,0,1,1, with the 1 received first. `full_match` is 1 exactly when `match_level` is 4.
- R3: `match_level` equals the length of the longest pattern prefix that is a suffix of the accepted bits. The bit stream 1 0 0 1 1 0 1 1 0 yields the levels 1 2 0 1 1 2 3 4 2, in that order.
- R4: Detection overlaps. From level 4, an accepted 0 gives level 2 and an accepted 1 gives level 1.
- R5: The LEDs are active low and form a thermometer. `led_n[i]` is 0 exactly when `match_level` is greater than i. `led_n[0]` lights first.
- R6: Buttons are active low, and a pin reading 0 means pressed. A press held for any length enters exactly one bit. Releasing the button enters none.
- R7: A button level reaches the state machine only after it has stayed unchanged for `DEBOUNCE_CYCLES` consecutive clocks past the synchroniser. A shorter pulse enters no bit.
- R8: If both buttons yield a debounced press edge on the same clock, that input is ignored and `match_level` is unchanged.
- R9: Without an accepted bit, `match_level` and `led_n` hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| btn_zero_n | input | 1 | Active-low button that enters a 0 |
| btn_one_n | input | 1 | Active-low button that enters a 1 |
| led_n | output | 4 | Active-low thermometer LEDs |
| match_level | output | 3 | Current matched prefix length, 0 to 4 |
| full_match | output | 1 | High while all four pattern bits are matched |

## Verification
The in-RTL assertions check four properties on every clock:
- The debounced level only flips once the stability counter has reached its limit.
- A press pulse never lasts two cycles.
- The level moves by at most one step upward, holds without an accepted bit and ignores coincident presses.
- The number of lit LEDs tracks the level.

The overlap behaviour can only be shown by the bench's scenarios: the worked example sequence, the two exits from a full match, mid-stream reset, and the rejection of short glitches at the pins.

// File: rtl/seqgauge_pkg.sv
package seqgauge_pkg;
  localparam int DEF_PAT_LEN  = 4;
  localparam logic [DEF_PAT_LEN-1:0] DEF_PATTERN = 4'b1011;
  localparam int DEF_DEBOUNCE = 65536;
endpackage

// File: rtl/seqgauge_btn_cond.sv
module seqgauge_btn_cond #(
  parameter int DEBOUNCE_CYCLES = seqgauge_pkg::DEF_DEBOUNCE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic press_pulse
);
  localparam int CNT_W = (DEBOUNCE_CYCLES > 2) ? $clog2(DEBOUNCE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(DEBOUNCE_CYCLES - 1);

  logic sync_a, sync_b;
  logic sampled;
  logic deb_q, deb_d;
  logic deb_prev;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // two-flop synchroniser, reset to released
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 1'b1;
      sync_b <= 1'b1;
    end else begin
      sync_a <= pin_n;
      sync_b <= sync_a;
    end
  end

  assign sampled = ~sync_b;

  // stability counter: next-state logic
  always_comb begin
    cnt_d = '0;
    deb_d = deb_q;
    if (sampled != deb_q) begin
      if (cnt_q == CNT_LIM) begin
        deb_d = sampled;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      deb_q    <= 1'b0;
      deb_prev <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      deb_q    <= deb_d;
      deb_prev <= deb_q;
    end
  end

  assign press_pulse = deb_q & ~deb_prev;

  // R7: debounced level flips only after a full stability window
  assert_debounce_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(deb_q) |-> $past(cnt_q) == CNT_LIM);

  // R6: one press gives a single-cycle pulse
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    press_pulse |=> !press_pulse);
endmodule

// File: rtl/seqgauge_fsm.sv
module seqgauge_fsm #(
  parameter int PAT_LEN = seqgauge_pkg::DEF_PAT_LEN,
  parameter logic [PAT_LEN-1:0] PATTERN = seqgauge_pkg::DEF_PATTERN,
  localparam int LVL_W = $clog2(PAT_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zero_pulse,
  input  logic             one_pulse,
  output logic [LVL_W-1:0] level
);
  logic [LVL_W-1:0] level_d;
  logic             bit_valid;

  // pattern bit i, i = 0 being the first received (MSB of PATTERN)
  function automatic logic pat_bit(input int i);
    return PATTERN[PAT_LEN-1-i];
  endfunction

  // longest pattern prefix that ends the string (prefix of length lvl, then b)
  function automatic logic [LVL_W-1:0] step(input logic [LVL_W-1:0] lvl, input logic b);
    int   best;
    int   idx;
    int   cur;
    logic ok;
    logic sbit;
    best = 0;
    cur  = int'(lvl);
    for (int k = 1; k <= PAT_LEN; k++) begin
      if (k <= cur + 1) begin
        ok = 1'b1;
        for (int j = 0; j < k; j++) begin
          idx = cur + 1 - k + j;
          if (idx < cur) sbit = pat_bit(idx);
          else           sbit = b;
          if (sbit != pat_bit(j)) ok = 1'b0;
        end
        if (ok) best = k;
      end
    end
    return LVL_W'(best);
  endfunction

  assign bit_valid = zero_pulse ^ one_pulse;

  always_comb begin
    level_d = level;
    if (bit_valid) level_d = step(level, one_pulse);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= '0;
    else        level <= level_d;
  end

  // R3: level never exceeds the pattern length and grows by at most one
  assert_level_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= PAT_LEN);
  assert_grow_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> int'(level) <= int'($past(level)) + 1);
  // R9: no accepted bit, no change
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_pulse && !one_pulse) |=> $stable(level));
  // R8: coincident presses are ignored
  assert_both_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_pulse && one_pulse) |=> $stable(level));
endmodule

// File: rtl/seqgauge_top.sv
module seqgauge_top #(
  parameter int DEBOUNCE_CYCLES = seqgauge_pkg::DEF_DEBOUNCE,
  parameter int PAT_LEN = seqgauge_pkg::DEF_PAT_LEN,
  parameter logic [PAT_LEN-1:0] PATTERN = seqgauge_pkg::DEF_PATTERN,
  localparam int LVL_W = $clog2(PAT_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               btn_zero_n,
  input  logic               btn_one_n,
  output logic [PAT_LEN-1:0] led_n,
  output logic [LVL_W-1:0]   match_level,
  output logic               full_match
);
  logic [1:0] pins_n;
  logic [1:0] pulses;

  assign pins_n = {btn_one_n, btn_zero_n};

  for (genvar g = 0; g < 2; g++) begin : g_btn
    seqgauge_btn_cond #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_cond (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_n      (pins_n[g]),
      .press_pulse(pulses[g])
    );
  end

  seqgauge_fsm #(.PAT_LEN(PAT_LEN), .PATTERN(PATTERN)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .zero_pulse(pulses[0]),
    .one_pulse (pulses[1]),
    .level     (match_level)
  );

  for (genvar i = 0; i < PAT_LEN; i++) begin : g_led
    assign led_n[i] = !(int'(match_level) > i);
  end

  assign full_match = (int'(match_level) == PAT_LEN);

  // R5: lit LED count follows the level
  assert_led_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~led_n) == int'(match_level));
  // R1: reset leaves every LED dark
  assert_reset_dark_R1: assert property (@(posedge clk)
    !rst_n |=> (led_n == '1 && !full_match));
endmodule

// File: tb/seqgauge_top_test.sv
module seqgauge_top_test;
  localparam int DEB  = 8;
  localparam int HOLD = 30;
  localparam int NV   = 9;
  localparam logic STIM [NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam int   EXPL [NV] = '{1, 2, 0, 1, 1, 2, 3, 4, 2};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       btn_zero_n = 1'b1;
  logic       btn_one_n = 1'b1;
  logic [3:0] led_n;
  logic [2:0] match_level;
  logic       full_match;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  seqgauge_top #(.DEBOUNCE_CYCLES(DEB)) uut (
    .clk(clk), .rst_n(rst_n), .btn_zero_n(btn_zero_n), .btn_one_n(btn_one_n),
    .led_n(led_n), .match_level(match_level), .full_match(full_match)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int therm_n(input int lvl);
    int v = 0;
    for (int i = 0; i < 4; i++) if (!(lvl > i)) v |= (1 << i);
    return v;
  endfunction

  task automatic check_level(input string req, input int lvl);
    @(negedge clk);
    chk(req, int'(match_level), lvl);
    chk({req, " leds"}, int'(led_n), therm_n(lvl));
    chk({req, " full"}, int'(full_match), (lvl == 4) ? 1 : 0);
  endtask

  task automatic press(input logic b, input int hold);
    @(negedge clk);
    if (b) btn_one_n = 1'b0; else btn_zero_n = 1'b0;
    repeat (hold) @(negedge clk);
    btn_one_n = 1'b1; btn_zero_n = 1'b1;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 level in reset", int'(match_level), 0);
    chk("R1 leds in reset", int'(led_n), 4'hF);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    repeat (20) @(negedge clk);
    check_level("R1 after release", 0);

    // R3 / R2: worked example walked from the table
    for (int v = 0; v < NV; v++) begin
      press(STIM[v], HOLD);
      check_level($sformatf("R3 vector %0d", v), EXPL[v]);
    end

    // R4: exit from full match with a 1
    do_reset();
    press(1'b1, HOLD); press(1'b0, HOLD); press(1'b1, HOLD); press(1'b1, HOLD);
    check_level("R2 full match", 4);
    press(1'b1, HOLD);
    check_level("R4 full then 1", 1);

    // R6: long hold enters one bit
    press(1'b0, 120);
    check_level("R6 long hold one bit", 2);

    // R9: idle holds
    repeat (60) @(negedge clk);
    check_level("R9 idle hold", 2);

    // R7: short glitch on the one button is not a bit
    press(1'b1, 3);
    check_level("R7 glitch ignored", 2);

    // R8: both buttons together ignored
    @(negedge clk);
    btn_zero_n = 1'b0; btn_one_n = 1'b0;
    repeat (HOLD) @(negedge clk);
    btn_zero_n = 1'b1; btn_one_n = 1'b1;
    repeat (HOLD) @(negedge clk);
    check_level("R8 both ignored", 2);

    // mid-stream reset back to zero
    press(1'b1, HOLD);
    check_level("R3 reach three", 3);
    do_reset();
    repeat (5) @(negedge clk);
    check_level("R1 reset mid stream", 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule